// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the processor-facing half of an I2C master. A simple bus with chip select, write enable and a word-aligned byte address reaches a small bank of registers: a read-only version word, a slave-address word, a control word, a status word, a divider, a transfer count, an interrupt enable mask, a pending word and a write-one-to-clear word. Two data ports sit at fixed offsets. Writing one of them queues an outgoing byte. Reading the other takes the oldest incoming byte.

The outgoing and incoming bytes pass through two synchronous first-word-fall-through FIFOs. The bit-level engine, which lives outside this block, sees the head of the transmit FIFO on its data output and pops it with a strobe. It pushes received bytes with a second strobe, and it reports a missing acknowledge or a bad data count on two event strobes. The engine gets its configuration straight from the register outputs: the enable, a one-cycle start pulse, the repeated-start request, the slave address, the divider and the transfer count.

Four events can become pending. Two are FIFO watermarks, each with its own programmable threshold. The other two are the acknowledge error and the count error. One level interrupt goes to the platform interrupt controller.

Top module: `i2c_regfront`

## Requirements
- R1: After reset the registers read as follows. Version (0x00) gives the VERSION parameter. Slave address (0x04), control (0x08), count (0x18), enable (0x1C) and pending (0x20) give 0. Divider (0x28) gives 499. Status (0x0C) gives 0x20. `irq` is low.
- R2: The slave-address register keeps bits [15:0] and reads 0 above them. Bit 0 is read/not-write, bits [7:1] are the device address and bits [15:8] are the internal register address. The 16 bits drive `eng_slave_addr`.
- R3: Writing 1 to control bit 0 raises `eng_start` for exactly one cycle after the write edge. Control bit 0 then reads back as 0. A start written while the pulse is high is absorbed.
- R4: Control fields are: write threshold [3:1], read threshold [7:4], repeated start bit 8 (drives `eng_restart`) and global enable bit 31 (drives `eng_enable`).
- R5: Each write to 0x10 pushes bus_wdata[7:0] into the transmit FIFO. `eng_tx_data` shows the oldest byte whenever `eng_tx_valid` is high, and `eng_tx_pop` removes it. Bytes leave in the order they were written.
- R6: Status fields are: bit 0 transmit FIFO full, [4:1] transmit count, bit 5 receive FIFO empty, [9:6] receive count. A write to 0x10 while the transmit FIFO is full is dropped.
- R7: `eng_rx_push` stores `eng_rx_data`. A read of 0x14 returns the oldest byte in bits [7:0] and removes it. When the FIFO is empty the read returns 0 and removes nothing.
- R8: While enabled, pending bit 0 sets on each edge where the transmit count is at or below the write threshold. Pending bit 1 sets on each edge where the receive count is at or above the read threshold.
- R9: While enabled, `eng_nack` sets pending bit 2 and `eng_cnt_err` sets pending bit 3 at the next edge.
- R10: Writing 1s to 0x24 clears those pending bits. When an event for a bit arrives on the same edge, the event wins and the bit stays set.
- R11: `irq` is the OR of (pending AND enable mask), forced low while the global enable is 0.
- R12: While the global enable is 0, no pending bit becomes set.
- R13: The divider (0x28, 16 bits) and count (0x18, 8 bits) registers read back as written and drive `eng_div` and `eng_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Register access select |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt request |
| eng_enable | output | 1 | Global enable |
| eng_start | output | 1 | One-cycle transaction start |
| eng_restart | output | 1 | Repeated-start request |
| eng_slave_addr | output | 16 | Direction, device and internal address |
| eng_div | output | 16 | Bit-rate divider |
| eng_count | output | 8 | Transfer byte count |
| eng_tx_data | output | 8 | Head of transmit FIFO |
| eng_tx_valid | output | 1 | Transmit FIFO not empty |
| eng_tx_pop | input | 1 | Remove head of transmit FIFO |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_push | input | 1 | Store received byte |
| eng_nack | input | 1 | No-acknowledge event strobe |
| eng_cnt_err | input | 1 | Data count error strobe |

## Verification
The hardest case to reach is a clear that loses to an event in the same cycle. The transmit watermark is a level condition, so the stimulus leaves the transmit FIFO at or below its threshold while clearing bit 0, and checks that the bit survives. It then pushes one byte to remove the condition and shows that the same clear now takes effect. Overflow needs the transmit FIFO filled to its full depth before one extra write. The drop is then proved through the status count and through the exact sequence of bytes the engine pops afterwards.

// File: rtl/i2c_regfront_pkg.sv
package i2c_regfront_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;
    localparam int BYTE_W = 8;
    localparam int IRQ_N  = 4;
    localparam int WWM_W  = 3;
    localparam int RWM_W  = 4;
    localparam int SLV_W  = 16;

    localparam int CTRL_START   = 0;
    localparam int CTRL_WWM     = 1;
    localparam int CTRL_RWM     = 4;
    localparam int CTRL_RESTART = 8;
    localparam int CTRL_EN      = 31;

    localparam int ST_WFULL  = 0;
    localparam int ST_WCNT   = 1;
    localparam int ST_REMPTY = 5;
    localparam int ST_RCNT   = 6;

    localparam int EV_WWM  = 0;
    localparam int EV_RWM  = 1;
    localparam int EV_NACK = 2;
    localparam int EV_CERR = 3;

    typedef enum logic [3:0] {
        REG_VER   = 4'd0,
        REG_SLV   = 4'd1,
        REG_CTRL  = 4'd2,
        REG_STAT  = 4'd3,
        REG_TXD   = 4'd4,
        REG_RXD   = 4'd5,
        REG_CNT   = 4'd6,
        REG_IEN   = 4'd7,
        REG_IPEND = 4'd8,
        REG_ICLR  = 4'd9,
        REG_DIV   = 4'd10,
        REG_NONE  = 4'd15
    } reg_e;

    typedef struct packed {
        logic             en;
        logic             restart;
        logic [RWM_W-1:0] rwm;
        logic [WWM_W-1:0] wwm;
    } ctrl_t;

    function automatic reg_e decode_word(input logic [BUS_AW-3:0] word);
        reg_e r;
        r = REG_NONE;
        if (word <= (BUS_AW-2)'(10)) r = reg_e'(word[3:0]);
        return r;
    endfunction

    function automatic logic [BUS_DW-1:0] ctrl_word(input ctrl_t c, input logic start);
        logic [BUS_DW-1:0] w;
        w = '0;
        w[CTRL_START]               = start;
        w[CTRL_WWM +: WWM_W]        = c.wwm;
        w[CTRL_RWM +: RWM_W]        = c.rwm;
        w[CTRL_RESTART]             = c.restart;
        w[CTRL_EN]                  = c.en;
        return w;
    endfunction

endpackage

// File: rtl/i2c_fwft_fifo.sv
module i2c_fwft_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rptr, wptr;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rptr];
    assign count   = cnt;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr <= '0;
            wptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok) wptr <= nxt(wptr);
            if (pop_ok)  rptr <= nxt(rptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH)); // R6
    AST_PUSH_COUNT: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (cnt == $past(cnt) + 1'b1)); // R5
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> (cnt == '0)); // R7
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] pend,
    output logic         irq
);
    logic [N-1:0] evt_g;

    assign evt_g = evt & {N{en}};
    assign irq   = en && ((pend & mask) != '0);

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | evt_g;
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        (evt_g != '0) |=> ((pend & $past(evt_g)) == $past(evt_g))); // R10
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~evt_g) != '0) |=> ((pend & $past(clr & ~evt_g)) == '0)); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !en |-> !irq); // R11
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> ((pend & ~$past(pend)) == '0)); // R12
endmodule

// File: rtl/i2c_regfront.sv
module i2c_regfront
    import i2c_regfront_pkg::*;
#(
    parameter int          FIFO_DEPTH = 8,
    parameter int          DIV_W      = 16,
    parameter int          CNT_W      = 8,
    parameter logic [31:0] VERSION    = 32'h0001_0003,
    parameter int          DIV_RESET  = 499
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              eng_enable,
    output logic              eng_start,
    output logic              eng_restart,
    output logic [15:0]       eng_slave_addr,
    output logic [DIV_W-1:0]  eng_div,
    output logic [CNT_W-1:0]  eng_count,
    output logic [7:0]        eng_tx_data,
    output logic              eng_tx_valid,
    input  logic              eng_tx_pop,
    input  logic [7:0]        eng_rx_data,
    input  logic              eng_rx_push,
    input  logic              eng_nack,
    input  logic              eng_cnt_err
);
    localparam int CW = $clog2(FIFO_DEPTH+1);

    reg_e              sel;
    logic              wr, rd;
    ctrl_t             ctrl_q;
    logic              start_q;
    logic [SLV_W-1:0]  slv_q;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IRQ_N-1:0]  ien_q, pend, evt, clr;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic [BYTE_W-1:0] rx_head;
    logic [BUS_DW-1:0] status;
    logic              unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[30:16], rx_full};

    assign sel = decode_word(bus_addr[7:2]);
    assign wr  = bus_cs && bus_we;
    assign rd  = bus_cs && !bus_we;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            start_q <= 1'b0;
            slv_q   <= '0;
            div_q   <= DIV_W'(DIV_RESET);
            cnt_q   <= '0;
            ien_q   <= '0;
        end else begin
            start_q <= wr && (sel == REG_CTRL) && bus_wdata[CTRL_START] && !start_q;
            if (wr) begin
                case (sel)
                    REG_SLV: slv_q <= bus_wdata[SLV_W-1:0];
                    REG_CTRL: begin
                        ctrl_q.wwm     <= bus_wdata[CTRL_WWM +: WWM_W];
                        ctrl_q.rwm     <= bus_wdata[CTRL_RWM +: RWM_W];
                        ctrl_q.restart <= bus_wdata[CTRL_RESTART];
                        ctrl_q.en      <= bus_wdata[CTRL_EN];
                    end
                    REG_DIV: div_q <= bus_wdata[DIV_W-1:0];
                    REG_CNT: cnt_q <= bus_wdata[CNT_W-1:0];
                    REG_IEN: ien_q <= bus_wdata[IRQ_N-1:0];
                    default: ;
                endcase
            end
        end
    end

    i2c_fwft_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (wr && (sel == REG_TXD)),
        .din   (bus_wdata[BYTE_W-1:0]),
        .pop   (eng_tx_pop),
        .dout  (eng_tx_data),
        .empty (tx_empty),
        .full  (tx_full),
        .count (tx_cnt)
    );

    i2c_fwft_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (eng_rx_push),
        .din   (eng_rx_data),
        .pop   (rd && (sel == REG_RXD)),
        .dout  (rx_head),
        .empty (rx_empty),
        .full  (rx_full),
        .count (rx_cnt)
    );

    // event sources
    always_comb begin
        evt          = '0;
        evt[EV_WWM]  = 32'(tx_cnt) <= 32'(ctrl_q.wwm);
        evt[EV_RWM]  = 32'(rx_cnt) >= 32'(ctrl_q.rwm);
        evt[EV_NACK] = eng_nack;
        evt[EV_CERR] = eng_cnt_err;
        clr          = (wr && (sel == REG_ICLR)) ? bus_wdata[IRQ_N-1:0] : '0;
    end

    i2c_irq_ctrl #(.N(IRQ_N)) u_irq (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl_q.en),
        .evt  (evt),
        .clr  (clr),
        .mask (ien_q),
        .pend (pend),
        .irq  (irq)
    );

    always_comb begin
        status                    = '0;
        status[ST_WFULL]          = tx_full;
        status[ST_WCNT +: CW]     = tx_cnt;
        status[ST_REMPTY]         = rx_empty;
        status[ST_RCNT +: CW]     = rx_cnt;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (sel)
                REG_VER:   bus_rdata = VERSION;
                REG_SLV:   bus_rdata = BUS_DW'(slv_q);
                REG_CTRL:  bus_rdata = ctrl_word(ctrl_q, start_q);
                REG_STAT:  bus_rdata = status;
                REG_RXD:   bus_rdata = rx_empty ? '0 : BUS_DW'(rx_head);
                REG_CNT:   bus_rdata = BUS_DW'(cnt_q);
                REG_IEN:   bus_rdata = BUS_DW'(ien_q);
                REG_IPEND: bus_rdata = BUS_DW'(pend);
                REG_DIV:   bus_rdata = BUS_DW'(div_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign eng_enable     = ctrl_q.en;
    assign eng_start      = start_q;
    assign eng_restart    = ctrl_q.restart;
    assign eng_slave_addr = slv_q;
    assign eng_div        = div_q;
    assign eng_count      = cnt_q;
    assign eng_tx_valid   = !tx_empty;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start); // R3
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_start) |-> $past(wr && (sel == REG_CTRL) && bus_wdata[CTRL_START])); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (tx_full && !eng_tx_pop) |=> tx_full); // R6
endmodule

// File: tb/sim_i2c_regfront.sv
`timescale 1ns/1ps
module sim_i2c_regfront;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_cs = 0, bus_we = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq, eng_enable, eng_start, eng_restart, eng_tx_valid;
    logic [15:0] eng_slave_addr, eng_div;
    logic [7:0]  eng_count, eng_tx_data;
    logic        eng_tx_pop = 0, eng_rx_push = 0, eng_nack = 0, eng_cnt_err = 0;
    logic [7:0]  eng_rx_data = 0;

    int checks = 0, failures = 0;
    logic [31:0] exp_q[$];
    string       req_q[$];
    logic        mon_en = 0;
    logic        done = 0;

    always #2 clk = ~clk;

    i2c_regfront u0 (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .eng_enable(eng_enable), .eng_start(eng_start), .eng_restart(eng_restart),
        .eng_slave_addr(eng_slave_addr), .eng_div(eng_div), .eng_count(eng_count),
        .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid), .eng_tx_pop(eng_tx_pop),
        .eng_rx_data(eng_rx_data), .eng_rx_push(eng_rx_push), .eng_nack(eng_nack),
        .eng_cnt_err(eng_cnt_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data and compares at the falling edge
    always @(negedge clk) begin
        if (mon_en && exp_q.size() > 0) begin
            logic [31:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(r, bus_rdata, e);
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_cs = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string req);
        @(posedge clk); #1;
        exp_q.push_back(e); req_q.push_back(req);
        bus_cs = 1; bus_we = 0; bus_addr = a; mon_en = 1;
        @(posedge clk); #1;
        bus_cs = 0; mon_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(posedge clk); #1; eng_rx_push = 1; eng_rx_data = d;
        @(posedge clk); #1; eng_rx_push = 0;
    endtask

    task automatic tx_pop();
        @(posedge clk); #1; eng_tx_pop = 1;
        @(posedge clk); #1; eng_tx_pop = 0;
    endtask

    task automatic pulse_nack();
        @(posedge clk); #1; eng_nack = 1;
        @(posedge clk); #1; eng_nack = 0;
    endtask

    task automatic pulse_cerr();
        @(posedge clk); #1; eng_cnt_err = 1;
        @(posedge clk); #1; eng_cnt_err = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1;
        idle(3);
        rst = 0;
        idle(1);

        // R1 reset state
        bus_rd(8'h00, 32'h0001_0003, "R1 version");
        bus_rd(8'h04, 32'h0, "R1 slave");
        bus_rd(8'h08, 32'h0, "R1 ctrl");
        bus_rd(8'h0C, 32'h20, "R1 status");
        bus_rd(8'h18, 32'h0, "R1 count");
        bus_rd(8'h1C, 32'h0, "R1 ien");
        bus_rd(8'h20, 32'h0, "R1 pend");
        bus_rd(8'h28, 32'd499, "R1 div");
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 slave address
        bus_wr(8'h04, 32'hFFFF_A5B7);
        bus_rd(8'h04, 32'h0000_A5B7, "R2 slave readback");
        chk("R2 eng_slave_addr", {16'b0, eng_slave_addr}, 32'hA5B7);

        // R3 start pulse
        bus_wr(8'h08, 32'h0000_0001);
        chk("R3 start high", {31'b0, eng_start}, 32'h1);
        idle(1);
        chk("R3 start low", {31'b0, eng_start}, 32'h0);
        bus_rd(8'h08, 32'h0, "R3 ctrl bit0 self-clear");

        // R5 transmit FIFO order, R6 status
        bus_wr(8'h10, 32'h11);
        bus_wr(8'h10, 32'h22);
        bus_wr(8'h10, 32'h33);
        bus_rd(8'h0C, 32'h26, "R6 status three queued");
        chk("R5 head valid", {31'b0, eng_tx_valid}, 32'h1);
        chk("R5 head first", {24'b0, eng_tx_data}, 32'h11);
        tx_pop();
        chk("R5 head after pop", {24'b0, eng_tx_data}, 32'h22);
        for (int i = 0; i < 6; i++) bus_wr(8'h10, 32'h40 + i);
        bus_rd(8'h0C, 32'h31, "R6 status full");
        bus_wr(8'h10, 32'hEE);
        bus_rd(8'h0C, 32'h31, "R6 status after dropped write");
        chk("R5 order 0", {24'b0, eng_tx_data}, 32'h22); tx_pop();
        chk("R5 order 1", {24'b0, eng_tx_data}, 32'h33); tx_pop();
        for (int i = 0; i < 6; i++) begin
            chk("R6 order after overflow", {24'b0, eng_tx_data}, 32'h40 + i);
            tx_pop();
        end
        chk("R6 overflow byte absent", {31'b0, eng_tx_valid}, 32'h0);
        bus_rd(8'h0C, 32'h20, "R6 status drained");

        // R7 receive FIFO
        rx_push(8'hA1);
        rx_push(8'hA2);
        bus_rd(8'h0C, 32'h80, "R6 status two received");
        bus_rd(8'h14, 32'hA1, "R7 first rx byte");
        bus_rd(8'h14, 32'hA2, "R7 second rx byte");
        bus_rd(8'h14, 32'h0, "R7 empty read");
        bus_rd(8'h0C, 32'h20, "R7 status after empty read");

        // R12 events ignored while disabled
        pulse_nack();
        pulse_cerr();
        idle(2);
        bus_rd(8'h20, 32'h0, "R12 pend stays clear");

        // R4 control, R8 write watermark
        bus_wr(8'h08, 32'h8000_0020);
        chk("R4 enable out", {31'b0, eng_enable}, 32'h1);
        bus_rd(8'h08, 32'h8000_0020, "R4 ctrl readback");
        idle(2);
        bus_rd(8'h20, 32'h1, "R8 write watermark pending");
        chk("R11 masked irq", {31'b0, irq}, 32'h0);
        bus_wr(8'h1C, 32'h1);
        chk("R11 irq on enable mask", {31'b0, irq}, 32'h1);

        // R10 event beats clear, then clear works
        bus_wr(8'h24, 32'h1);
        bus_rd(8'h20, 32'h1, "R10 event wins over clear");
        bus_wr(8'h10, 32'h77);
        idle(1);
        bus_wr(8'h24, 32'h1);
        bus_rd(8'h20, 32'h0, "R10 clear takes effect");
        chk("R11 irq drops", {31'b0, irq}, 32'h0);

        // R8 read watermark, R9 error events
        rx_push(8'hB1);
        rx_push(8'hB2);
        idle(2);
        bus_rd(8'h20, 32'h2, "R8 read watermark pending");
        chk("R11 read wm masked", {31'b0, irq}, 32'h0);
        bus_wr(8'h1C, 32'hF);
        chk("R11 irq all mask", {31'b0, irq}, 32'h1);
        pulse_nack();
        pulse_cerr();
        bus_rd(8'h20, 32'hE, "R9 nack and count error");
        bus_wr(8'h24, 32'hC);
        bus_rd(8'h20, 32'h2, "R10 partial clear");
        bus_rd(8'h14, 32'hB1, "R7 rx B1");
        bus_rd(8'h14, 32'hB2, "R7 rx B2");
        bus_wr(8'h24, 32'h2);
        bus_rd(8'h20, 32'h0, "R10 clear read wm");
        chk("R11 irq idle", {31'b0, irq}, 32'h0);

        // R11 global gate
        pulse_nack();
        chk("R11 irq on nack", {31'b0, irq}, 32'h1);
        bus_wr(8'h08, 32'h0000_0020);
        chk("R11 irq gated by enable", {31'b0, irq}, 32'h0);
        bus_rd(8'h20, 32'h4, "R11 pend kept while gated");

        // R4 restart, R13 divider and count
        bus_wr(8'h08, 32'h0000_0100);
        chk("R4 restart out", {31'b0, eng_restart}, 32'h1);
        chk("R4 enable off", {31'b0, eng_enable}, 32'h0);
        bus_rd(8'h08, 32'h0000_0100, "R4 ctrl restart readback");
        bus_wr(8'h28, 32'h0000_1234);
        bus_rd(8'h28, 32'h1234, "R13 div readback");
        chk("R13 eng_div", {16'b0, eng_div}, 32'h1234);
        bus_wr(8'h18, 32'h5A);
        bus_rd(8'h18, 32'h5A, "R13 count readback");
        chk("R13 eng_count", {24'b0, eng_count}, 32'h5A);

        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule